// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible state of one DMA channel that serves a single peripheral. A host reaches four 32-bit registers through a small word-addressed bus: a control and status word, a DMA address word, a spare data word and an upper-address extension word. The block drives one interrupt line toward the host. The attached peripheral asks it to raise or clear that interrupt. The block sends a one-cycle reset pulse to the peripheral when software asks for one. It also merges the extension word into every address the peripheral issues.

Writes to the control word have side effects. Software can reset the peripheral, clear the drain flag, or set the drain flag by writing zero. The stored word always carries a fixed version code in its top nibble. A write to the address word marks the address as loaded in the control word. A chip that needs two channels instantiates the block twice, with the two windows 16 bytes apart.

Top module: `dma_chan_csr`

## Requirements
- R1: After synchronous reset the control word (index 0) reads 0xA0000000, indices 1 to 3 read 0, and irq_out and dev_rst are low.
- R2: The register index is bus_addr[3:2], and bus_addr[1:0] has no effect. Read data appears on bus_rdata one cycle after bus_rd. A read changes no register. A write to index 2 stores the value unchanged.
- R3: Bits 31:28 of every stored control word are forced to 0xA, whatever value was written.
- R4: A control write with bit 4 (interrupt enable) clear forces irq_out low on the next cycle.
- R5: A control write with bit 7 (device reset) set drives dev_rst high for the one cycle after the write. In that case bit 6 (drain) is stored as written.
- R6: A control write with bit 7 clear and bit 6 set stores bit 6 as 0.
- R7: A control write of exactly zero stores 0xA0000040.
- R8: A write to index 1 stores the value and sets bit 26 (address loaded) of the control word.
- R9: irq_raise sets control bit 0 and drives irq_out high on the next cycle. irq_clear, when irq_raise is low, clears both. If both requests are high, the raise wins.
- R10: When irq_raise coincides with a control write that has bit 4 clear, irq_out goes low and control bit 0 is set.
- R11: dev_addr_out equals dev_addr_in bitwise-ORed with the index 3 register, one cycle after dev_addr_in is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_raise | input | 1 | Peripheral request to raise the interrupt |
| irq_clear | input | 1 | Peripheral request to clear the interrupt |
| irq_out | output | 1 | Interrupt to the host, registered |
| dev_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dev_addr_in | input | 32 | DMA address from the peripheral |
| dev_addr_out | output | 32 | DMA address with the extension bits merged in |

## Verification
Every result takes exactly one register stage. A write is visible on a later read. irq_out and dev_rst change one cycle after the write or request. bus_rdata is valid one cycle after bus_rd. dev_addr_out follows dev_addr_in by one cycle. The bench changes inputs on the falling edge and holds each strobe for a single cycle. It samples at the next falling edge, which is the first point where the one-stage result is due. For the pulse checks it samples one more falling edge to confirm that dev_rst has dropped again.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int BIT_PEND    = 0;
  localparam int BIT_IEN     = 4;
  localparam int BIT_DRAIN   = 6;
  localparam int BIT_DEVRST  = 7;
  localparam int BIT_TOMEM   = 8;
  localparam int BIT_LOADED  = 26;
  localparam int VER_W       = 4;
  localparam logic [VER_W-1:0] VERSION = 4'hA;
  localparam int IDX_CTRL    = 0;
  localparam int IDX_ADDR    = 1;
  localparam int IDX_EXT     = 3;
endpackage

// File: rtl/dcsr_decode.sv
module dcsr_decode #(
  parameter int OFS_W = 4,
  localparam int IDX_W = OFS_W - 2,
  localparam int NREG  = 2 ** IDX_W
) (
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  output logic [NREG-1:0]  wr_sel,
  output logic [IDX_W-1:0] idx
);
  logic unused_lo;
  assign unused_lo = ^bus_addr[1:0];
  assign idx = bus_addr[OFS_W-1:2];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = bus_wr && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/dcsr_ctrl.sv
module dcsr_ctrl
  import dcsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              addr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_raise,
  input  logic              irq_clear,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              irq_q,
  output logic              rst_pulse_q
);
  localparam logic [DATA_W-1:0] RST_VAL = {VERSION, {(DATA_W-VER_W){1'b0}}};

  logic [DATA_W-1:0] wv, nxt;
  logic              rst_req, irq_n;

  always_comb begin
    wv      = wdata;
    rst_req = 1'b0;
    if (wdata[BIT_DEVRST]) rst_req = 1'b1;
    else if (wdata[BIT_DRAIN]) wv[BIT_DRAIN] = 1'b0;
    else if (wdata == '0) wv[BIT_DRAIN] = 1'b1;
    wv[DATA_W-1 -: VER_W] = VERSION;

    nxt = ctrl_q;
    if (ctrl_wr) nxt = wv;
    if (addr_wr) nxt[BIT_LOADED] = 1'b1;
    if (irq_clear) nxt[BIT_PEND] = 1'b0;
    if (irq_raise) nxt[BIT_PEND] = 1'b1;

    irq_n = irq_q;
    if (irq_raise) irq_n = 1'b1;
    else if (irq_clear) irq_n = 1'b0;
    if (ctrl_wr && !wdata[BIT_IEN]) irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= RST_VAL;
      irq_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      ctrl_q      <= nxt;
      irq_q       <= irq_n;
      rst_pulse_q <= ctrl_wr && rst_req;
    end
  end
endmodule

// File: rtl/dcsr_datareg.sv
module dcsr_datareg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/dcsr_addr_ext.sv
module dcsr_addr_ext #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] ext_bits,
  input  logic [DATA_W-1:0] addr_in,
  output logic [DATA_W-1:0] addr_out
);
  always_ff @(posedge clk) addr_out <= addr_in | ext_bits;
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dcsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_raise,
  input  logic              irq_clear,
  output logic              irq_out,
  output logic              dev_rst,
  input  logic [DATA_W-1:0] dev_addr_in,
  output logic [DATA_W-1:0] dev_addr_out
);
  localparam int IDX_W = OFS_W - 2;
  localparam int NREG  = 2 ** IDX_W;

  logic [NREG-1:0]   wr_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] reg_q [NREG];

  dcsr_decode #(.OFS_W(OFS_W)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_sel(wr_sel), .idx(idx)
  );

  dcsr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr_sel[IDX_CTRL]), .addr_wr(wr_sel[IDX_ADDR]),
    .wdata(bus_wdata), .irq_raise(irq_raise), .irq_clear(irq_clear),
    .ctrl_q(reg_q[IDX_CTRL]), .irq_q(irq_out), .rst_pulse_q(dev_rst)
  );

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    dcsr_datareg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst(rst), .we(wr_sel[i]), .wdata(bus_wdata), .q(reg_q[i])
    );
  end

  dcsr_addr_ext #(.DATA_W(DATA_W)) u_ext (
    .clk(clk), .ext_bits(reg_q[IDX_EXT]),
    .addr_in(dev_addr_in), .addr_out(dev_addr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= reg_q[idx];
  end
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [OFS_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_raise,
  input logic              irq_clear,
  input logic              irq_out,
  input logic              dev_rst,
  input logic [DATA_W-1:0] dev_addr_in,
  input logic [DATA_W-1:0] dev_addr_out
);
  logic ctrl_hit;
  assign ctrl_hit = bus_addr[OFS_W-1:2] == '0;

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_hit && !bus_wdata[4]) |=> !irq_out); // R4
  AST_RST_SRC: assert property (@(posedge clk) disable iff (rst)
    dev_rst |-> $past(bus_wr && ctrl_hit && bus_wdata[7])); // R5
  AST_RST_FIRE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_hit && bus_wdata[7]) |=> dev_rst); // R5
  AST_VER_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ctrl_hit) |=> bus_rdata[DATA_W-1 -: 4] == 4'hA); // R3
  AST_RAISE: assert property (@(posedge clk) disable iff (rst)
    (irq_raise && !(bus_wr && ctrl_hit && !bus_wdata[4])) |=> irq_out); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irq_clear && !irq_raise) |=> !irq_out); // R9
  AST_EXT_OR: assert property (@(posedge clk) disable iff (rst)
    ((dev_addr_out & $past(dev_addr_in)) == $past(dev_addr_in))); // R11
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_raise(irq_raise),
  .irq_clear(irq_clear), .irq_out(irq_out), .dev_rst(dev_rst),
  .dev_addr_in(dev_addr_in), .dev_addr_out(dev_addr_out)
);

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_raise = 1'b0, irq_clear = 1'b0, irq_out, dev_rst;
  logic [31:0] dev_addr_in = '0, dev_addr_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_raise(irq_raise),
    .irq_clear(irq_clear), .irq_out(irq_out), .dev_rst(dev_rst),
    .dev_addr_in(dev_addr_in), .dev_addr_out(dev_addr_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 dev_rst", {31'b0, dev_rst}, 32'h0);
    rd(4'h0, d); check("R1 ctrl", d, 32'hA0000000);
    for (int i = 1; i < 4; i++) begin
      rd(4'(i * 4), d); check("R1 reg", d, 32'h0);
    end
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(4'hB, 32'hDEADBEEF);
    rd(4'h8, d); check("R2 idx2 store", d, 32'hDEADBEEF);
    rd(4'hA, d); check("R2 low bits ignored/no side effect", d, 32'hDEADBEEF);
    rd(4'h1, d); check("R2 ctrl unchanged by reads", d, 32'hA0000000);
  endtask

  task automatic t_ctrl_writes();
    logic [31:0] d;
    wr(4'h0, 32'h000000C1);
    check("R5 pulse high", {31'b0, dev_rst}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, dev_rst}, 32'h0);
    rd(4'h0, d); check("R5 drain kept with reset", d, 32'hA00000C1);
    wr(4'h0, 32'h12345650);
    check("R6 no pulse", {31'b0, dev_rst}, 32'h0);
    rd(4'h0, d); check("R6 drain cleared, R3 version", d, 32'hA2345610);
    wr(4'h0, 32'h5FFFFF3F);
    rd(4'h0, d); check("R3 version forced", d, 32'hAFFFFF3F);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R7 zero write", d, 32'hA0000040);
  endtask

  task automatic t_addr_load();
    logic [31:0] d;
    wr(4'h4, 32'h00ABCDE0);
    rd(4'h4, d); check("R8 addr stored", d, 32'h00ABCDE0);
    rd(4'h0, d); check("R8 loaded bit", d, 32'hA4000040);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(4'h0, 32'h00000010);
    irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
    check("R9 raise irq", {31'b0, irq_out}, 32'h1);
    rd(4'h0, d); check("R9 pend bit", d, 32'hA0000011);
    irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
    check("R9 clear irq", {31'b0, irq_out}, 32'h0);
    rd(4'h0, d); check("R9 pend cleared", d, 32'hA0000010);
    irq_raise = 1'b1; irq_clear = 1'b1; @(negedge clk);
    irq_raise = 1'b0; irq_clear = 1'b0;
    check("R9 raise wins", {31'b0, irq_out}, 32'h1);
    wr(4'h0, 32'h00000020);
    check("R4 enable clear drops irq", {31'b0, irq_out}, 32'h0);
    wr(4'h0, 32'h00000010);
    bus_addr = 4'h0; bus_wdata = 32'h00000020; bus_wr = 1'b1; irq_raise = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_raise = 1'b0;
    check("R10 write beats raise", {31'b0, irq_out}, 32'h0);
    rd(4'h0, d); check("R10 pend follows raise", d, 32'hA0000021);
  endtask

  task automatic t_ext();
    wr(4'hC, 32'h00FF0000);
    dev_addr_in = 32'h0F001234; @(negedge clk);
    check("R11 merge", dev_addr_out, 32'h0FFF1234);
    dev_addr_in = 32'h00F000F0; @(negedge clk);
    check("R11 overlap", dev_addr_out, 32'h00FF00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_ctrl_writes();
    t_addr_load();
    t_irq();
    t_ext();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule